// File: doc/BRIEF.md
# Phase-Modulating Sigma-Delta Divider Control

This block sits between a baseband phase source and the feedback divider of a fractional-N synthesizer. Once per reference cycle it takes a 16-bit phase sample and takes the difference from the previous sample, so that the rest of the chain works on instantaneous frequency. A first-difference boost filter then strengthens fast frequency changes, which the closed PLL loop would otherwise attenuate. The channel's fractional word is added to the result, and a third-order cascaded sigma-delta modulator noise-shapes the sum into a small signed divide offset.

The divider applies nominal N plus that offset on each reference cycle, so the divide value lies between N-3 and N+4. The integer part of the channel word is passed through to a separate nominal-N output, delayed so that it lines up with the offset stream.

Top module: `phase_sdm_divctl`

## Requirements
- R1: A synchronous active-high reset clears every register, so that `div_offset` and `nominal_n` read 0. After reset, a phase input held at 0 together with `chan_frac` = 0 keeps `div_offset` at 0 on every cycle.
- R2: `div_offset` is a 5-bit two's-complement value and always lies in the range -3..+4.
- R3: Over a long window, the sum of the `div_offset` values equals the window length times `chan_frac`/2^20, within ±4.
- R4: The frequency term is (phase[n] - phase[n-1]) mod 2^16, read as signed and multiplied by 16, which gives units of 2^-20 of a divide step. A phase ramp that wraps from 0xFFFF to 0 therefore counts as a small positive step.
- R5: A phase ramp that falls by 0x2000 per cycle lowers the mean offset by 1/8 relative to `chan_frac` alone.
- R6: The boosted frequency is y = x + floor(k·(x - x_prev)/4), where k = `emph_gain` (0..15). With k = 0, or when x does not change, y equals x.
- R7: y saturates to the signed 20-bit range -2^19..2^19-1.
- R8: The modulator input is `chan_frac` + y, clamped to 0..2^20-1. It never wraps.
- R9: `nominal_n` equals `chan_int` delayed by exactly two clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock, one edge per divider cycle |
| rst | input | 1 | Synchronous active-high reset |
| phase_in | input | 16 | Baseband phase sample, one full turn = 2^16 |
| emph_gain | input | 4 | Boost gain k, in units of 1/4 |
| chan_int | input | 8 | Integer part of the channel divide word |
| chan_frac | input | 20 | Fractional part of the channel divide word, unsigned |
| div_offset | output | 5 | Signed divide offset from nominal N, -3..+4 |
| nominal_n | output | 8 | Integer divide value, aligned with `div_offset` |

## Verification
The assertions check four things on every cycle: the offset range, the cleared state just after reset, the pass-through of the boost filter when the gain is zero or the frequency is steady, and the clamp of a negative sum to zero. They also check the two-cycle alignment of the nominal divide value. What the modulator does on average can only be seen over many cycles, so the directed scenarios show it. These scenarios cover the fractional mean, wrap handling in the differencer, negative frequency, the size of the boost on an alternating frequency, saturation at high gain and clamping at the top of the range. Each of them sums the offsets over a window and compares the total with the value the requirements give.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  localparam int PHASE_BITS = 16;
  localparam int ACC_BITS   = 20;
  localparam int GAIN_BITS  = 4;
  localparam int NINT_BITS  = 8;
  localparam int OFFS_BITS  = 5;
  localparam int OFFS_MIN   = -3;
  localparam int OFFS_MAX   = 4;
endpackage

// File: rtl/phase_diff.sv
module phase_diff #(
  parameter int PHASE_W = sdm_pkg::PHASE_BITS,
  parameter int ACC_W   = sdm_pkg::ACC_BITS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] phase_in,
  output logic [ACC_W-1:0]   freq_q
);
  localparam int SHIFT = ACC_W - PHASE_W;

  logic [PHASE_W-1:0] prev_q;
  logic [PHASE_W-1:0] step;

  // modulo subtraction: a wrap gives a small signed step
  assign step = phase_in - prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      freq_q <= '0;
    end else begin
      prev_q <= phase_in;
      freq_q <= {step, {SHIFT{1'b0}}};
    end
  end
endmodule

// File: rtl/preemph.sv
module preemph #(
  parameter int ACC_W = sdm_pkg::ACC_BITS,
  parameter int K_W   = sdm_pkg::GAIN_BITS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [K_W-1:0]          gain,
  input  logic signed [ACC_W-1:0] x_in,
  output logic signed [ACC_W-1:0] y_q
);
  localparam int D_W   = ACC_W + 1;
  localparam int P_W   = D_W + K_W + 1;
  localparam int S_W   = P_W + 1;
  localparam logic signed [S_W-1:0] Y_MAX = S_W'((64'sd1 <<< (ACC_W-1)) - 1);
  localparam logic signed [S_W-1:0] Y_MIN = -Y_MAX - 1;

  logic signed [ACC_W-1:0] x_prev;
  logic signed [P_W-1:0]   g_ext, d_ext, prod;
  logic signed [S_W-1:0]   sum;

  always_comb begin
    d_ext = P_W'(x_in) - P_W'(x_prev);
    g_ext = $signed({{(P_W-K_W){1'b0}}, gain});
    prod  = g_ext * d_ext;
    sum   = S_W'(x_in) + S_W'(prod >>> 2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_prev <= '0;
      y_q    <= '0;
    end else begin
      x_prev <= x_in;
      if (sum > Y_MAX)      y_q <= ACC_W'(Y_MAX);
      else if (sum < Y_MIN) y_q <= ACC_W'(Y_MIN);
      else                  y_q <= ACC_W'(sum);
    end
  end

  a_r6_k0_passthrough: assert property (@(posedge clk) disable iff (rst)
    (gain == '0) |=> (y_q == $past(x_in)));
  a_r6_steady_passthrough: assert property (@(posedge clk) disable iff (rst)
    (x_in == x_prev) |=> (y_q == $past(x_in)));
endmodule

// File: rtl/chan_comb.sv
module chan_comb #(
  parameter int ACC_W  = sdm_pkg::ACC_BITS,
  parameter int NINT_W = sdm_pkg::NINT_BITS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [ACC_W-1:0] y_in,
  input  logic [ACC_W-1:0]        frac,
  input  logic [NINT_W-1:0]       nint,
  output logic [ACC_W-1:0]        word_q,
  output logic [NINT_W-1:0]       nint_q
);
  localparam int C_W = ACC_W + 2;
  localparam logic signed [C_W-1:0] TOP = C_W'((64'sd1 <<< ACC_W) - 1);

  logic signed [C_W-1:0] total;

  assign total = $signed({2'b00, frac}) + $signed({{2{y_in[ACC_W-1]}}, y_in});

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      nint_q <= '0;
    end else begin
      nint_q <= nint;
      if (total < 0)        word_q <= '0;
      else if (total > TOP) word_q <= ACC_W'(TOP);
      else                  word_q <= ACC_W'(total);
    end
  end

  a_r8_clamp_low: assert property (@(posedge clk) disable iff (rst)
    ((frac == '0) && y_in[ACC_W-1]) |=> (word_q == '0));
endmodule

// File: rtl/mash111.sv
module mash111 #(
  parameter int ACC_W = sdm_pkg::ACC_BITS,
  parameter int OFF_W = sdm_pkg::OFFS_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] word,
  output logic [OFF_W-1:0] offset_q
);
  localparam int STAGES = 3;

  logic [ACC_W-1:0] acc_q [STAGES];
  logic [ACC_W:0]   s     [STAGES];
  logic [STAGES-1:0] c;
  logic c2_d, c3_d, c3_dd;
  logic [OFF_W-1:0] off_n;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign s[g] = {1'b0, acc_q[g]} + {1'b0, word};
      end else begin : g_next
        assign s[g] = {1'b0, acc_q[g]} + {1'b0, s[g-1][ACC_W-1:0]};
      end
      assign c[g] = s[g][ACC_W];
      always_ff @(posedge clk) begin
        if (rst) acc_q[g] <= '0;
        else     acc_q[g] <= s[g][ACC_W-1:0];
      end
    end
  endgenerate

  // carry recombination: c1 + d(c2) + d2(c3)
  always_comb begin
    off_n = OFF_W'(c[0]) + OFF_W'(c[1]) - OFF_W'(c2_d)
          + OFF_W'(c[2]) - (OFF_W'(c3_d) << 1) + OFF_W'(c3_dd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c2_d <= 1'b0; c3_d <= 1'b0; c3_dd <= 1'b0;
      offset_q <= '0;
    end else begin
      c2_d  <= c[1];
      c3_d  <= c[2];
      c3_dd <= c3_d;
      offset_q <= off_n;
    end
  end

  a_r2_offset_range: assert property (@(posedge clk) disable iff (rst)
    ($signed(offset_q) >= sdm_pkg::OFFS_MIN) && ($signed(offset_q) <= sdm_pkg::OFFS_MAX));
endmodule

// File: rtl/phase_sdm_divctl.sv
module phase_sdm_divctl #(
  parameter int PHASE_W = sdm_pkg::PHASE_BITS,
  parameter int ACC_W   = sdm_pkg::ACC_BITS,
  parameter int K_W     = sdm_pkg::GAIN_BITS,
  parameter int NINT_W  = sdm_pkg::NINT_BITS,
  parameter int OFF_W   = sdm_pkg::OFFS_BITS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] phase_in,
  input  logic [K_W-1:0]     emph_gain,
  input  logic [NINT_W-1:0]  chan_int,
  input  logic [ACC_W-1:0]   chan_frac,
  output logic [OFF_W-1:0]   div_offset,
  output logic [NINT_W-1:0]  nominal_n
);
  logic [ACC_W-1:0]        freq;
  logic signed [ACC_W-1:0] boosted;
  logic [ACC_W-1:0]        word;
  logic [NINT_W-1:0]       nint_mid;

  phase_diff #(.PHASE_W(PHASE_W), .ACC_W(ACC_W)) u_diff (
    .clk(clk), .rst(rst), .phase_in(phase_in), .freq_q(freq));

  preemph #(.ACC_W(ACC_W), .K_W(K_W)) u_emph (
    .clk(clk), .rst(rst), .gain(emph_gain), .x_in($signed(freq)), .y_q(boosted));

  chan_comb #(.ACC_W(ACC_W), .NINT_W(NINT_W)) u_comb (
    .clk(clk), .rst(rst), .y_in(boosted), .frac(chan_frac), .nint(chan_int),
    .word_q(word), .nint_q(nint_mid));

  mash111 #(.ACC_W(ACC_W), .OFF_W(OFF_W)) u_mash (
    .clk(clk), .rst(rst), .word(word), .offset_q(div_offset));

  always_ff @(posedge clk) begin
    if (rst) nominal_n <= '0;
    else     nominal_n <= nint_mid;
  end

  logic [1:0] settle_q;
  always_ff @(posedge clk) begin
    if (rst)                 settle_q <= '0;
    else if (settle_q != 2'd2) settle_q <= settle_q + 2'd1;
  end

  a_r1_cleared_after_reset: assert property (@(posedge clk)
    ($past(rst) && !rst) |-> ((div_offset == '0) && (nominal_n == '0)));
  a_r9_nominal_align: assert property (@(posedge clk) disable iff (rst)
    (settle_q == 2'd2) |-> (nominal_n == $past(chan_int, 2)));
endmodule

// File: tb/test_phase_sdm_divctl.sv
module test_phase_sdm_divctl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] phase_in = '0;
  logic [3:0]  emph_gain = '0;
  logic [7:0]  chan_int = '0;
  logic [19:0] chan_frac = '0;
  logic [4:0]  div_offset;
  logic [7:0]  nominal_n;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #2 clk = ~clk;

  phase_sdm_divctl i_phase_sdm_divctl (
    .clk(clk), .rst(rst), .phase_in(phase_in), .emph_gain(emph_gain),
    .chan_int(chan_int), .chan_frac(chan_frac),
    .div_offset(div_offset), .nominal_n(nominal_n));

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected under 150000", cycles);
      report();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    phase_in = '0;
    rst = 1'b0;
  endtask

  // drives a phase pattern, sums offsets over n cycles after a warm-up
  task automatic run_window(input int n, input logic [15:0] step, input bit alt,
                            output int sum, output int bad);
    logic [15:0] base;
    sum = 0; bad = 0; base = phase_in;
    for (int i = 0; i < n + 8; i++) begin
      @(negedge clk);
      if (i >= 8) begin
        sum += int'($signed(div_offset));
        if ($signed(div_offset) < -3 || $signed(div_offset) > 4) bad++;
      end
      if (alt) phase_in = (i % 2 == 0) ? base + step : base;
      else     phase_in = phase_in + step;
    end
  endtask

  task automatic chk_mean(input string req, input int n, input int sum, input real per);
    real e;
    e = real'(n) * per / 1048576.0;
    chk((real'(sum) - e <= 4.0) && (e - real'(sum) <= 4.0), req, sum, int'(e));
  endtask

  task automatic t_reset_state;  // R1
    rst = 1'b1; phase_in = 16'hBEEF; chan_int = 8'hA5; chan_frac = 20'hFFFFF; emph_gain = 4'd9;
    repeat (3) @(negedge clk);
    chk(div_offset == 5'd0, "R1 reset offset", int'(div_offset), 0);
    chk(nominal_n == 8'd0, "R1 reset nominal", int'(nominal_n), 0);
  endtask

  task automatic t_zero_hold;  // R1
    int nz;
    chan_frac = '0; emph_gain = 4'd7; chan_int = 8'h10;
    do_reset();
    nz = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (div_offset != 5'd0) nz++;
    end
    chk(nz == 0, "R1 zero input holds zero", nz, 0);
  endtask

  task automatic t_frac_mean;  // R2, R3
    int s, b;
    emph_gain = '0; chan_frac = 20'h40000;
    do_reset();
    run_window(400, 16'd0, 1'b0, s, b);
    chk_mean("R3 mean quarter", 400, s, 262144.0);
    chk(b == 0, "R2 range quarter", b, 0);
    chan_frac = 20'hB3333;
    do_reset();
    run_window(500, 16'd0, 1'b0, s, b);
    chk_mean("R3 mean 0.7", 500, s, 734003.0);
    chk(b == 0, "R2 range 0.7", b, 0);
  endtask

  task automatic t_wrap;  // R4
    int s, b;
    emph_gain = '0; chan_frac = '0;
    do_reset();
    run_window(800, 16'h2000, 1'b0, s, b);
    chk_mean("R4 wrapping ramp", 800, s, 131072.0);
  endtask

  task automatic t_falling;  // R5
    int s, b;
    emph_gain = '0; chan_frac = 20'h80000;
    do_reset();
    run_window(800, 16'hE000, 1'b0, s, b);
    chk_mean("R5 falling ramp", 800, s, 393216.0);
  endtask

  task automatic t_emphasis;  // R6 R7 R8
    int s, b;
    chan_frac = '0;
    emph_gain = 4'd0;
    do_reset();
    run_window(640, 16'h1000, 1'b1, s, b);
    chk_mean("R6 k=0 alternating", 640, s, 32768.0);
    emph_gain = 4'd8;
    do_reset();
    run_window(640, 16'h1000, 1'b1, s, b);
    chk_mean("R6 k=8 boost", 640, s, 163840.0);
    emph_gain = 4'd15;
    do_reset();
    run_window(640, 16'h1000, 1'b1, s, b);
    chk_mean("R7 k=15 saturation", 640, s, 262143.5);
    chk(b == 0, "R2 range boosted", b, 0);
  endtask

  task automatic t_clamp_high;  // R8
    int s, b;
    emph_gain = '0; chan_frac = 20'hF0000;
    do_reset();
    run_window(400, 16'h4000, 1'b0, s, b);
    chk_mean("R8 clamp high", 400, s, 1048575.0);
    chk(b == 0, "R2 range clamp", b, 0);
  endtask

  task automatic t_nominal;  // R9
    emph_gain = '0; chan_frac = '0; chan_int = 8'h00;
    do_reset();
    @(negedge clk); chan_int = 8'h5A;
    @(posedge clk); @(negedge clk);
    chk(nominal_n == 8'h00, "R9 not after one cycle", int'(nominal_n), 0);
    @(posedge clk); @(negedge clk);
    chk(nominal_n == 8'h5A, "R9 after two cycles", int'(nominal_n), 8'h5A);
    chan_int = 8'hC3;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(nominal_n == 8'hC3, "R9 second value", int'(nominal_n), 8'hC3);
  endtask

  initial begin
    t_reset_state();
    t_zero_hold();
    t_frac_mean();
    t_wrap();
    t_falling();
    t_emphasis();
    t_clamp_high();
    t_nominal();
    report();
  end
endmodule